// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Assembler

This block sits between instruction memory and decode. It takes 16-bit instruction halfwords one at a time, with a valid strobe, and tracks the address of the halfword it needs next. It classifies each leading halfword by its upper byte. From that class it knows whether one extension halfword follows. It then emits one assembled instruction record. The record holds the opcode byte, two register indices, a fully extended 32-bit immediate, the address of the instruction, its length in halfwords, the address of the instruction that follows, and an illegal flag.

Where the immediate is split, the bits in the leading halfword are the upper part and the extension halfword supplies the low 16 bits. Short formats carry their immediates entirely in the leading halfword. In formats that name a base register from the upper bank with two bits, those two bits are remapped into r8 to r11. A redirect drops any half-built instruction and restarts fetch at a new halfword-aligned address.

Top module: `insn_assembler`

## Requirements
- R1: After reset, `fetch_pc` equals parameter RESET_PC (default 0) and `ins_valid` is low.
- R2: A one-halfword instruction accepted at a clock edge is presented on the outputs from the next edge, with `ins_valid` high for one cycle, `ins_len`=1, `ins_opcode` = halfword bits [15:8], and `ins_next_pc` = `ins_pc`+2.
- R3: Opcodes 0x04-0x06, 0x0A, 0x0B, 0x40-0x5F, 0x64-0x66, 0xA0-0xAF and 0xC8 take one extension halfword. The instruction is presented only from the edge after the extension is accepted, with `ins_len`=2, `ins_pc` = address of the leading halfword and `ins_next_pc` = `ins_pc`+4.
- R4: Extended immediates: opcodes 0x40-0x5F give sign-extend24({lead[11:4], ext}); 0xA0-0xAF give sign-extend28({lead[11:0], ext}); the other extended opcodes give sign-extend16(ext).
- R5: Short immediates come from the leading halfword: 0x20-0x3F sign-extend lead[11:4]; 0x80-0x8F zero-extend lead[11:4]; 0xB0-0xBF sign-extend lead[11:0]; 0x7C-0x7F, 0xC7 and 0xC9 sign-extend lead[7:4]; 0xD0-0xD5 zero-extend lead[8:4]; 0x0C-0x1F and 0x68-0x73 zero-extend lead[9:4]. All other opcodes give 0.
- R6: `ins_ra` = lead[3:0] and `ins_rb` = lead[7:4], except for opcodes 0x0C-0x1F and 0x68-0x73, where `ins_ra` = 8 + lead[1:0] and `ins_rb` = lead[3:2].
- R7: `ins_illegal` is set for opcodes 0x93-0x9F, 0xD6-0xDF and 0xE4-0xFF. It is also set for 0x63, 0x90 and 0x91 with lead[7:4] nonzero, and for 0x67 and 0xE0-0xE3 with lead[7:0] nonzero. An illegal instruction has `ins_len`=1 and immediate 0.
- R8: `fetch_pc` advances by 2 for every accepted halfword and holds, with no instruction emitted, in cycles where `hw_valid` is low.
- R9: With `redirect` high, the halfword offered in that cycle is ignored, any half-built instruction is dropped, no instruction is emitted at the next edge, and `fetch_pc` becomes `redirect_pc` with bit 0 cleared.
- R10: Idle cycles between a leading halfword and its extension do not disturb assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | `hw_data` holds the halfword at `fetch_pc` |
| hw_data | input | 16 | Instruction halfword |
| redirect | input | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | input | AW | New fetch address |
| fetch_pc | output | AW | Address of the halfword wanted next |
| ins_valid | output | 1 | Assembled instruction present |
| ins_opcode | output | 8 | Upper byte of the leading halfword |
| ins_ra | output | 4 | First register index |
| ins_rb | output | 4 | Second register index |
| ins_imm | output | 32 | Merged, extended immediate |
| ins_pc | output | AW | Address of the leading halfword |
| ins_next_pc | output | AW | Address after the last halfword |
| ins_len | output | 2 | Length in halfwords (1 or 2) |
| ins_illegal | output | 1 | Encoding is invalid |

## Verification
The stream mixes short instructions of every immediate class with signed and unsigned payloads whose top bit is set. This shows sign extension apart from zero extension, and the high-register remap apart from the plain nibble fields. Each extended class is sent with a negative and a positive merged value, back to back and with idle gaps before the extension. This confirms which bits land high and low, and that gaps neither emit early nor lose the leading halfword. Hole opcodes and reserved-bit violations sit beside legal neighbours that differ in one field. Redirects are issued both mid-instruction and while idle, to an odd address, to show the partial word is dropped and bit 0 is cleared.

// File: rtl/insn_asm_pkg.sv
package insn_asm_pkg;

  localparam int HALF_W = 16;
  localparam int IMM_W  = 32;

  typedef enum logic [3:0] {
    K_PLAIN, K_R4, K_NONE, K_HOLE,
    K_I4S, K_I5U, K_I6H, K_I8S, K_I8U, K_I12S,
    K_E16, K_I8E, K_I12E
  } kind_t;

  typedef enum logic {S_HEAD, S_TAIL} asm_state_t;

endpackage

// File: rtl/insn_class_dec.sv
module insn_class_dec
  import insn_asm_pkg::*;
(
  input  logic [7:0] op,
  input  logic [7:0] low,
  output kind_t      kind,
  output logic       needs_ext,
  output logic       illegal
);

  always_comb begin
    kind = K_PLAIN;
    if (op inside {[8'h04:8'h06], 8'h0A, 8'h0B, [8'h64:8'h66], 8'hC8}) kind = K_E16;
    else if (op inside {[8'h0C:8'h1F], [8'h68:8'h73]})                 kind = K_I6H;
    else if (op inside {[8'h20:8'h3F]})                                kind = K_I8S;
    else if (op inside {[8'h40:8'h5F]})                                kind = K_I8E;
    else if (op inside {8'h63, 8'h90, 8'h91})                          kind = K_R4;
    else if (op inside {8'h67, [8'hE0:8'hE3]})                         kind = K_NONE;
    else if (op inside {[8'h7C:8'h7F], 8'hC7, 8'hC9})                  kind = K_I4S;
    else if (op inside {[8'h80:8'h8F]})                                kind = K_I8U;
    else if (op inside {[8'h93:8'h9F], [8'hD6:8'hDF], [8'hE4:8'hFF]})  kind = K_HOLE;
    else if (op inside {[8'hA0:8'hAF]})                                kind = K_I12E;
    else if (op inside {[8'hB0:8'hBF]})                                kind = K_I12S;
    else if (op inside {[8'hD0:8'hD5]})                                kind = K_I5U;
  end

  always_comb begin
    needs_ext = (kind == K_E16) || (kind == K_I8E) || (kind == K_I12E);
    illegal   = (kind == K_HOLE)
             || ((kind == K_R4)   && (low[7:4] != 4'h0))
             || ((kind == K_NONE) && (low != 8'h00));
  end

endmodule

// File: rtl/insn_field_merge.sv
module insn_field_merge
  import insn_asm_pkg::*;
(
  input  kind_t              kind,
  input  logic [11:0]        lead,
  input  logic [HALF_W-1:0]  ext,
  output logic [IMM_W-1:0]   imm,
  output logic [3:0]         ra,
  output logic [3:0]         rb
);

  always_comb begin
    unique case (kind)
      K_I4S:   imm = {{28{lead[7]}}, lead[7:4]};
      K_I5U:   imm = {27'd0, lead[8:4]};
      K_I6H:   imm = {26'd0, lead[9:4]};
      K_I8S:   imm = {{24{lead[11]}}, lead[11:4]};
      K_I8U:   imm = {24'd0, lead[11:4]};
      K_I12S:  imm = {{20{lead[11]}}, lead[11:0]};
      K_E16:   imm = {{16{ext[15]}}, ext};
      K_I8E:   imm = {{8{lead[11]}}, lead[11:4], ext};
      K_I12E:  imm = {{4{lead[11]}}, lead[11:0], ext};
      default: imm = '0;
    endcase
  end

  always_comb begin
    if (kind == K_I6H) begin
      ra = {2'b10, lead[1:0]};
      rb = {2'b00, lead[3:2]};
    end else begin
      ra = lead[3:0];
      rb = lead[7:4];
    end
  end

endmodule

// File: rtl/insn_assembler.sv
module insn_assembler
  import insn_asm_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  input  logic [15:0]       hw_data,
  input  logic              redirect,
  input  logic [AW-1:0]     redirect_pc,
  output logic [AW-1:0]     fetch_pc,
  output logic              ins_valid,
  output logic [7:0]        ins_opcode,
  output logic [3:0]        ins_ra,
  output logic [3:0]        ins_rb,
  output logic [31:0]       ins_imm,
  output logic [AW-1:0]     ins_pc,
  output logic [AW-1:0]     ins_next_pc,
  output logic [1:0]        ins_len,
  output logic              ins_illegal
);

  localparam logic [AW-1:0] STEP    = AW'(2);
  localparam logic [AW-1:0] ALIGN_M = ~AW'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  asm_state_t        st_q, st_d;
  logic [AW-1:0]     pc_q, pc_d, start_q, start_d;
  logic [HALF_W-1:0] head_q, head_d, lead;

  kind_t             kind;
  logic              needs_ext, illegal;
  logic [IMM_W-1:0]  imm;
  logic [3:0]        ra, rb;

  logic              emit;
  logic [AW-1:0]     e_pc;
  logic [1:0]        e_len;

  assign lead = (st_q == S_TAIL) ? head_q : hw_data;

  insn_class_dec u_dec (
    .op        (lead[15:8]),
    .low       (lead[7:0]),
    .kind      (kind),
    .needs_ext (needs_ext),
    .illegal   (illegal)
  );

  insn_field_merge u_merge (
    .kind (kind),
    .lead (lead[11:0]),
    .ext  (hw_data),
    .imm  (imm),
    .ra   (ra),
    .rb   (rb)
  );

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    head_d  = head_q;
    start_d = start_q;
    emit    = 1'b0;
    e_pc    = pc_q;
    e_len   = 2'd1;
    if (redirect) begin
      st_d = S_HEAD;
      pc_d = redirect_pc & ALIGN_M;
    end else if (hw_valid) begin
      pc_d = pc_q + STEP;
      if (st_q == S_HEAD) begin
        if (needs_ext && !illegal) begin
          st_d    = S_TAIL;
          head_d  = hw_data;
          start_d = pc_q;
        end else begin
          emit = 1'b1;
        end
      end else begin
        emit  = 1'b1;
        e_pc  = start_q;
        e_len = 2'd2;
        st_d  = S_HEAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q      <= S_HEAD;
      pc_q      <= RESET_PC[AW-1:0];
      head_q    <= '0;
      start_q   <= '0;
      ins_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      pc_q      <= pc_d;
      head_q    <= head_d;
      start_q   <= start_d;
      ins_valid <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ins_opcode  <= '0;
      ins_ra      <= '0;
      ins_rb      <= '0;
      ins_imm     <= '0;
      ins_pc      <= '0;
      ins_next_pc <= '0;
      ins_len     <= '0;
      ins_illegal <= 1'b0;
    end else if (emit) begin
      ins_opcode  <= lead[15:8];
      ins_ra      <= ra;
      ins_rb      <= rb;
      ins_imm     <= imm;
      ins_pc      <= e_pc;
      ins_next_pc <= e_pc + AW'({e_len, 1'b0});
      ins_len     <= e_len;
      ins_illegal <= illegal;
    end
  end

  assign fetch_pc = pc_q;

endmodule

// File: rtl/insn_assembler_chk.sv
module insn_assembler_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_valid,
  input logic          redirect,
  input logic [AW-1:0] redirect_pc,
  input logic [AW-1:0] fetch_pc,
  input logic          ins_valid,
  input logic [7:0]    ins_opcode,
  input logic [3:0]    ins_ra,
  input logic [AW-1:0] ins_pc,
  input logic [AW-1:0] ins_next_pc,
  input logic [1:0]    ins_len,
  input logic          ins_illegal
);

  a_r3_next_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_next_pc == ins_pc + AW'({ins_len, 1'b0}));

  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> (ins_len == 2'd1 || ins_len == 2'd2));

  a_r7_illegal_short: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_illegal) |-> ins_len == 2'd1);

  a_r6_high_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (ins_opcode inside {[8'h0C:8'h1F], [8'h68:8'h73]}))
      |-> ins_ra[3:2] == 2'b10);

  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !redirect) |=> fetch_pc == $past(fetch_pc) + AW'(2));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_valid && !redirect) |=> ($stable(fetch_pc) && !ins_valid));

  a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!ins_valid && fetch_pc == ($past(redirect_pc) & ~AW'(1))));

endmodule

bind insn_assembler insn_assembler_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_ok),
  .hw_valid    (hw_valid),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .fetch_pc    (fetch_pc),
  .ins_valid   (ins_valid),
  .ins_opcode  (ins_opcode),
  .ins_ra      (ins_ra),
  .ins_pc      (ins_pc),
  .ins_next_pc (ins_next_pc),
  .ins_len     (ins_len),
  .ins_illegal (ins_illegal)
);

// File: tb/insn_assembler_test.sv
module insn_assembler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw_data = '0;
  logic        redirect = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic [31:0] fetch_pc, ins_pc, ins_next_pc, ins_imm;
  logic        ins_valid, ins_illegal;
  logic [7:0]  ins_opcode;
  logic [3:0]  ins_ra, ins_rb;
  logic [1:0]  ins_len;

  always #5 clk = ~clk;

  insn_assembler uut (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .redirect(redirect), .redirect_pc(redirect_pc), .fetch_pc(fetch_pc),
    .ins_valid(ins_valid), .ins_opcode(ins_opcode), .ins_ra(ins_ra),
    .ins_rb(ins_rb), .ins_imm(ins_imm), .ins_pc(ins_pc),
    .ins_next_pc(ins_next_pc), .ins_len(ins_len), .ins_illegal(ins_illegal)
  );

  typedef struct {
    logic [7:0]  op;
    logic [3:0]  ra, rb;
    logic [31:0] imm, pc, nxt;
    logic [1:0]  len;
    logic        ill;
  } exp_t;

  exp_t        exp_q[$];
  int          total = 0;
  int          bad = 0;
  logic [31:0] tb_pc = '0;
  bit          live = 1'b0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] m, input logic [15:0] e, input logic [31:0] pc);
    exp_t r;
    logic [7:0] op;
    op    = m[15:8];
    r.op  = op;
    r.ra  = m[3:0];
    r.rb  = m[7:4];
    r.imm = '0;
    r.len = 2'd1;
    r.ill = 1'b0;
    r.pc  = pc;
    if (op inside {[8'h40:8'h5F]}) begin
      r.len = 2'd2; r.imm = {{8{m[11]}}, m[11:4], e};
    end else if (op inside {[8'hA0:8'hAF]}) begin
      r.len = 2'd2; r.imm = {{4{m[11]}}, m[11:0], e};
    end else if (op inside {[8'h04:8'h06], 8'h0A, 8'h0B, [8'h64:8'h66], 8'hC8}) begin
      r.len = 2'd2; r.imm = {{16{e[15]}}, e};
    end else if (op inside {[8'h20:8'h3F]}) r.imm = {{24{m[11]}}, m[11:4]};
    else if (op inside {[8'h80:8'h8F]})     r.imm = {24'd0, m[11:4]};
    else if (op inside {[8'hB0:8'hBF]})     r.imm = {{20{m[11]}}, m[11:0]};
    else if (op inside {[8'h7C:8'h7F], 8'hC7, 8'hC9}) r.imm = {{28{m[7]}}, m[7:4]};
    else if (op inside {[8'hD0:8'hD5]})     r.imm = {27'd0, m[8:4]};
    else if (op inside {[8'h0C:8'h1F], [8'h68:8'h73]}) begin
      r.imm = {26'd0, m[9:4]};
      r.ra  = {2'b10, m[1:0]};
      r.rb  = {2'b00, m[3:2]};
    end
    if (op inside {[8'h93:8'h9F], [8'hD6:8'hDF], [8'hE4:8'hFF]}) r.ill = 1'b1;
    if (op inside {8'h63, 8'h90, 8'h91} && m[7:4] != 4'h0)        r.ill = 1'b1;
    if (op inside {8'h67, [8'hE0:8'hE3]} && m[7:0] != 8'h00)      r.ill = 1'b1;
    r.nxt = pc + {29'd0, r.len, 1'b0};
    return r;
  endfunction

  // driver side
  task automatic send(input logic [15:0] hw);
    @(negedge clk);
    chk(fetch_pc == tb_pc, "R8 fetch address", fetch_pc, tb_pc);
    hw_valid = 1'b1;
    hw_data  = hw;
    tb_pc    = tb_pc + 32'd2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(fetch_pc == tb_pc, "R8/R10 hold", fetch_pc, tb_pc);
      hw_valid = 1'b0;
      hw_data  = 16'hDEAD;
    end
  endtask

  task automatic put(input logic [15:0] m, input logic [15:0] e, input int gap);
    exp_t r;
    r = model(m, e, tb_pc);
    if (r.len == 2'd1) begin
      exp_q.push_back(r);
      send(m);
    end else begin
      send(m);
      if (gap > 0) idle(gap);
      exp_q.push_back(r);
      send(e);
    end
  endtask

  task automatic redir(input logic [31:0] addr);
    @(negedge clk);
    redirect    = 1'b1;
    redirect_pc = addr;
    hw_valid    = 1'b1;
    hw_data     = 16'h0712;
    @(negedge clk);
    redirect = 1'b0;
    hw_valid = 1'b0;
    tb_pc    = {addr[31:1], 1'b0};
    chk(fetch_pc == tb_pc, "R9 new fetch address", fetch_pc, tb_pc);
    chk(!ins_valid, "R9 nothing emitted", {31'd0, ins_valid}, 32'd0);
  endtask

  // monitor side
  always @(negedge clk) begin
    if (live && ins_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected instruction", ins_pc, 32'hFFFF_FFFF);
      end else begin
        exp_t r;
        r = exp_q.pop_front();
        chk(ins_opcode == r.op, "R2 opcode", {24'd0, ins_opcode}, {24'd0, r.op});
        chk(ins_len == r.len, "R3 length", {30'd0, ins_len}, {30'd0, r.len});
        chk(ins_pc == r.pc, "R3 instruction address", ins_pc, r.pc);
        chk(ins_next_pc == r.nxt, "R2/R3 next address", ins_next_pc, r.nxt);
        chk(ins_imm == r.imm, "R4/R5 immediate", ins_imm, r.imm);
        chk({ins_ra, ins_rb} == {r.ra, r.rb}, "R6 registers",
            {24'd0, ins_ra, ins_rb}, {24'd0, r.ra, r.rb});
        chk(ins_illegal == r.ill, "R7 illegal flag", {31'd0, ins_illegal}, {31'd0, r.ill});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(fetch_pc == 32'd0, "R1 reset address", fetch_pc, 32'd0);
    chk(!ins_valid, "R1 no output", {31'd0, ins_valid}, 32'd0);
    live = 1'b1;

    // R2, R5, R6: short formats back to back
    put(16'h0712, 16'h0, 0);
    put(16'h2A5F, 16'h0, 0);
    put(16'h8A5F, 16'h0, 0);
    put(16'hBF80, 16'h0, 0);
    put(16'h7C93, 16'h0, 0);
    put(16'hD1F0, 16'h0, 0);
    put(16'h0E7B, 16'h0, 0);
    put(16'h7245, 16'h0, 0);
    // R3, R4, R10: extended formats, with and without gaps
    put(16'h0634, 16'h8001, 0);
    put(16'h4C56, 16'h1234, 0);
    put(16'hA7FF, 16'hABCD, 3);
    put(16'hA800, 16'h0000, 1);
    put(16'hC812, 16'h7FFF, 0);
    put(16'h4312, 16'h0001, 2);
    // R7: holes and reserved bits, next to legal neighbours
    put(16'h9300, 16'h0, 0);
    put(16'hD700, 16'h0, 0);
    put(16'hF123, 16'h0, 0);
    put(16'hE400, 16'h0, 0);
    put(16'h6310, 16'h0, 0);
    put(16'h6301, 16'h0, 0);
    put(16'h9050, 16'h0, 0);
    put(16'h6701, 16'h0, 0);
    put(16'hE000, 16'h0, 0);
    idle(2);
    // R9: redirect drops a half-built instruction, odd target
    send(16'h4000);
    redir(32'h0000_0123);
    put(16'h0712, 16'h0, 0);
    put(16'h0504, 16'hFFFE, 0);
    // R9: redirect while idle, then an extended instruction across a gap
    idle(1);
    redir(32'h0000_4000);
    put(16'hA000, 16'h0010, 2);
    put(16'h2080, 16'h0, 0);
    idle(4);
    chk(exp_q.size() == 0, "R3 all instructions emitted", exp_q.size(), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule